// File: doc/BRIEF.md
# Program Address Sequencer with Three-Level Return Stack

This block steers the program address of a small 4-bit controller. It holds the program counter, the current page and chapter, and a page buffer and chapter buffer that stage the destination of the next far transfer. Each clock it applies one operation, given by a 3-bit code: step, branch, call, return, load page buffer or load chapter buffer. Branch and call are conditional on the status input. A taken transfer moves the PC to the low bits of the target field and moves the staged page and chapter into the current ones.

Subroutine linkage uses three shift-register stacks: one for the PC, one for the page and one for the chapter. All three are pushed by a taken call and popped by an honoured return. A thermometer-coded occupancy vector records how many levels are live. A return is honoured only when that vector shows at least one level. A call whose status is false does not jump. Instead it copies the current page and chapter back into the buffers, which cancels any staged far target.

Top module: `addr_sequencer`

## Requirements
- R1: After the asynchronous active-low reset, pc_o, page_o and chapter_o are 0, both buffers are 0 and the return stack is empty.
- R2: For op_i codes 0 (step), 4, 5, 6 and 7, pc_o advances by one, wrapping at 2^PC_W, on a clock where inc_en_i is 1. It holds on a clock where inc_en_i is 0. Codes 6 and 7 act as step. inc_en_i has no effect on codes 1 to 3.
- R3: Code 1 (branch) with status_i=1: pc_o takes target_i[PC_W-1:0], page_o takes the page buffer and chapter_o takes the chapter buffer on the next clock.
- R4: Code 1 with status_i=0 changes nothing. pc_o, page_o and chapter_o hold.
- R5: Code 2 (call) with status_i=1 pushes the current PC, page and chapter. It then loads pc_o, page_o and chapter_o as a taken branch does.
- R6: Code 2 with status_i=0 copies page_o into the page buffer and chapter_o into the chapter buffer. pc_o, page_o and chapter_o hold.
- R7: Code 3 (return) with a non-empty stack restores pc_o, page_o and chapter_o from the newest stack level. The restored page and chapter are also written into the page buffer and chapter buffer.
- R8: Code 3 with an empty stack changes nothing.
- R9: Nested calls up to three deep are unwound in last-in, first-out order.
- R10: A fourth nested call discards the oldest level. Only three of the following returns are honoured. The occupancy vector is always thermometer coded.
- R11: Code 4 loads the page buffer from target_i[3:0]. Code 5 loads the chapter buffer from target_i[1:0]. Neither changes page_o or chapter_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| status_i | input | 1 | Condition flag for branch and call |
| target_i | input | TGT_W | Opcode target field |
| inc_en_i | input | 1 | Sequential PC advance enable |
| pc_o | output | PC_W | Program counter |
| page_o | output | 4 | Current page |
| chapter_o | output | 2 | Current chapter |

## Verification
Long random streams mix all operation codes with random status, target and increment enable. This separates taken transfers from untaken ones and shows that the buffers reach the outputs only through a later branch or call. Directed sequences stage distinct pages and chapters before each of three nested calls. The PC, page and chapter are then unwound, which exposes any swapped or misordered stack level. A fourth call followed by four returns tells a dropping, saturating stack apart from a wrapping one. Returns issued straight after reset and after a full unwind show that an empty stack is left alone.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    OP_STEP   = 3'd0,
    OP_BRANCH = 3'd1,
    OP_CALL   = 3'd2,
    OP_RETURN = 3'd3,
    OP_LDPAGE = 3'd4,
    OP_LDCHAP = 3'd5
  } seq_op_e;

  localparam int unsigned PAGE_W = 4;
  localparam int unsigned CHAP_W = 2;
endpackage

// File: rtl/seq_shift_stack.sv
// Multi-level return storage kept as one shift register, newest level in the low bits.
module seq_shift_stack #(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o
);
  localparam int unsigned SW = W * DEPTH;

  logic [SW-1:0] stk_q, stk_d;
  logic          stk_en;

  assign stk_en = push_i | pop_i;

  generate
    if (DEPTH > 1) begin : g_multi
      always_comb begin
        stk_d = stk_q;
        if (push_i)     stk_d = {stk_q[SW-W-1:0], din_i};
        else if (pop_i) stk_d = {{W{1'b0}}, stk_q[SW-1:W]};
      end
    end else begin : g_single
      always_comb begin
        stk_d = stk_q;
        if (push_i)     stk_d = din_i;
        else if (pop_i) stk_d = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stk_q <= '0;
    else if (stk_en) stk_q <= stk_d;
  end

  assign top_o = stk_q[W-1:0];
endmodule

// File: rtl/seq_call_latch.sv
// Thermometer-coded occupancy of the return stack.
module seq_call_latch #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [DEPTH-1:0] vec_o,
  output logic             live_o
);
  logic [DEPTH-1:0] vec_q, vec_d;
  logic             vec_en;

  assign vec_en = push_i | pop_i;

  generate
    if (DEPTH > 1) begin : g_multi
      always_comb begin
        vec_d = vec_q;
        if (push_i)     vec_d = {vec_q[DEPTH-2:0], 1'b1};
        else if (pop_i) vec_d = {1'b0, vec_q[DEPTH-1:1]};
      end
    end else begin : g_single
      always_comb begin
        vec_d = vec_q;
        if (push_i)     vec_d = 1'b1;
        else if (pop_i) vec_d = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  assign vec_o  = vec_q;
  assign live_o = vec_q[0];
endmodule

// File: rtl/seq_bank_reg.sv
// Current/staged register pair for page or chapter.
module seq_bank_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         jump_i,
  input  logic         cancel_i,
  input  logic         restore_i,
  input  logic         stage_i,
  input  logic [W-1:0] stage_din_i,
  input  logic [W-1:0] pop_val_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] buf_o
);
  logic [W-1:0] cur_q, cur_d, buf_q, buf_d;
  logic         cur_en, buf_en;

  always_comb begin
    cur_d  = cur_q;
    buf_d  = buf_q;
    cur_en = 1'b0;
    buf_en = 1'b0;
    if (jump_i) begin
      cur_d  = buf_q;
      cur_en = 1'b1;
    end else if (restore_i) begin
      cur_d  = pop_val_i;
      buf_d  = pop_val_i;
      cur_en = 1'b1;
      buf_en = 1'b1;
    end else if (cancel_i) begin
      buf_d  = cur_q;
      buf_en = 1'b1;
    end else if (stage_i) begin
      buf_d  = stage_din_i;
      buf_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end

  assign cur_o = cur_q;
  assign buf_o = buf_q;
endmodule

// File: rtl/addr_sequencer.sv
module addr_sequencer #(
  parameter int unsigned PC_W  = 6,
  parameter int unsigned DEPTH = 3,
  parameter int unsigned TGT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic             status_i,
  input  logic [TGT_W-1:0] target_i,
  input  logic             inc_en_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [3:0]       page_o,
  output logic [1:0]       chapter_o
);
  import seq_pkg::*;

  seq_op_e          op;
  logic             is_xfer, br_take, call_take, call_skip, ret_take;
  logic             jump, ld_page, ld_chap, live;
  logic [DEPTH-1:0] clatch_vec;
  logic [PC_W-1:0]  pc_q, pc_d, pc_top;
  logic             pc_en;
  logic [PAGE_W-1:0] page_cur, page_buf, page_top;
  logic [CHAP_W-1:0] chap_cur, chap_buf, chap_top;

  // operation decode
  always_comb begin
    op        = seq_op_e'(op_i);
    is_xfer   = (op == OP_BRANCH) || (op == OP_CALL) || (op == OP_RETURN);
    br_take   = (op == OP_BRANCH) && status_i;
    call_take = (op == OP_CALL) && status_i;
    call_skip = (op == OP_CALL) && !status_i;
    ret_take  = (op == OP_RETURN) && live;
    jump      = br_take | call_take;
    ld_page   = (op == OP_LDPAGE);
    ld_chap   = (op == OP_LDCHAP);
  end

  // program counter next state
  always_comb begin
    pc_d  = pc_q;
    pc_en = 1'b0;
    if (jump) begin
      pc_d  = target_i[PC_W-1:0];
      pc_en = 1'b1;
    end else if (ret_take) begin
      pc_d  = pc_top;
      pc_en = 1'b1;
    end else if (!is_xfer && inc_en_i) begin
      pc_d  = pc_q + PC_W'(1);
      pc_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  seq_call_latch #(.DEPTH(DEPTH)) u_clatch (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .push_i (call_take), .pop_i (ret_take),
    .vec_o (clatch_vec), .live_o (live)
  );

  seq_shift_stack #(.W(PC_W), .DEPTH(DEPTH)) u_pc_stack (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .push_i (call_take), .pop_i (ret_take),
    .din_i (pc_q), .top_o (pc_top)
  );

  seq_shift_stack #(.W(PAGE_W), .DEPTH(DEPTH)) u_page_stack (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .push_i (call_take), .pop_i (ret_take),
    .din_i (page_cur), .top_o (page_top)
  );

  seq_shift_stack #(.W(CHAP_W), .DEPTH(DEPTH)) u_chap_stack (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .push_i (call_take), .pop_i (ret_take),
    .din_i (chap_cur), .top_o (chap_top)
  );

  seq_bank_reg #(.W(PAGE_W)) u_page (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .jump_i (jump), .cancel_i (call_skip), .restore_i (ret_take),
    .stage_i (ld_page), .stage_din_i (target_i[PAGE_W-1:0]),
    .pop_val_i (page_top), .cur_o (page_cur), .buf_o (page_buf)
  );

  seq_bank_reg #(.W(CHAP_W)) u_chap (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .jump_i (jump), .cancel_i (call_skip), .restore_i (ret_take),
    .stage_i (ld_chap), .stage_din_i (target_i[CHAP_W-1:0]),
    .pop_val_i (chap_top), .cur_o (chap_cur), .buf_o (chap_buf)
  );

  assign pc_o      = pc_q;
  assign page_o    = page_cur;
  assign chapter_o = chap_cur;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int unsigned PC_W  = 6,
  parameter int unsigned DEPTH = 3,
  parameter int unsigned TGT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic             status_i,
  input logic [TGT_W-1:0] target_i,
  input logic             inc_en_i,
  input logic [PC_W-1:0]  pc_o,
  input logic [3:0]       page_o,
  input logic [1:0]       chapter_o,
  input logic [3:0]       pbuf_i,
  input logic [1:0]       cbuf_i,
  input logic [DEPTH-1:0] latch_i
);
  logic             plain_op;
  logic [DEPTH-1:0] latch_p1;

  assign plain_op = (op_i == 3'd0) || (op_i > 3'd3);
  assign latch_p1 = latch_i + 1'b1;

  // R2
  step_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_op && inc_en_i |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  // R3
  branch_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1) && status_i |=>
      (pc_o == $past(target_i[PC_W-1:0])) && (page_o == $past(pbuf_i)) &&
      (chapter_o == $past(cbuf_i)));

  // R4
  branch_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1) && !status_i |=> $stable(pc_o) && $stable(page_o) && $stable(chapter_o));

  // R5
  call_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2) && status_i |=> latch_i[0]);

  // R6
  call_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2) && !status_i |=>
      (pbuf_i == $past(page_o)) && (cbuf_i == $past(chapter_o)) && $stable(pc_o));

  // R7
  ret_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd3) && latch_i[0] |=> (pbuf_i == page_o) && (cbuf_i == chapter_o));

  // R8
  ret_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd3) && !latch_i[0] |=> $stable(pc_o) && $stable(page_o) && $stable(chapter_o));

  // R10
  latch_thermo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_p1 & latch_i) == '0);
endmodule

bind addr_sequencer seq_checker #(.PC_W(PC_W), .DEPTH(DEPTH), .TGT_W(TGT_W)) u_seq_checker (
  .clk_i (clk_i), .rst_ni (rst_ni), .op_i (op_i), .status_i (status_i),
  .target_i (target_i), .inc_en_i (inc_en_i), .pc_o (pc_o), .page_o (page_o),
  .chapter_o (chapter_o), .pbuf_i (page_buf), .cbuf_i (chap_buf), .latch_i (clatch_vec)
);

// File: tb/test_addr_sequencer.sv
`timescale 1ns/1ps
module test_addr_sequencer;
  localparam int PC_W = 6;
  localparam int TGT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       op = 3'd0;
  logic             status = 1'b0;
  logic [TGT_W-1:0] target = '0;
  logic             inc_en = 1'b0;
  logic [PC_W-1:0]  pc;
  logic [3:0]       page;
  logic [1:0]       chapter;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  int m_pc, m_pg, m_ch, m_pb, m_cb, m_dep;
  int s_pc[3], s_pg[3], s_ch[3];

  always #5 clk = ~clk;

  addr_sequencer #(.PC_W(PC_W), .DEPTH(3), .TGT_W(TGT_W)) i_addr_sequencer (
    .clk_i (clk), .rst_ni (rst_n), .op_i (op), .status_i (status),
    .target_i (target), .inc_en_i (inc_en), .pc_o (pc), .page_o (page),
    .chapter_o (chapter)
  );

  function automatic void model_reset();
    m_pc = 0; m_pg = 0; m_ch = 0; m_pb = 0; m_cb = 0; m_dep = 0;
    for (int i = 0; i < 3; i++) begin s_pc[i] = 0; s_pg[i] = 0; s_ch[i] = 0; end
  endfunction

  function automatic void model_step(int o, int st, int tg, int inc);
    int mask = (1 << PC_W) - 1;
    case (o)
      1: if (st != 0) begin m_pc = tg & mask; m_pg = m_pb; m_ch = m_cb; end
      2: if (st != 0) begin
           for (int i = 2; i > 0; i--) begin
             s_pc[i] = s_pc[i-1]; s_pg[i] = s_pg[i-1]; s_ch[i] = s_ch[i-1];
           end
           s_pc[0] = m_pc; s_pg[0] = m_pg; s_ch[0] = m_ch;
           if (m_dep < 3) m_dep++;
           m_pc = tg & mask; m_pg = m_pb; m_ch = m_cb;
         end else begin
           m_pb = m_pg; m_cb = m_ch;
         end
      3: if (m_dep > 0) begin
           m_pc = s_pc[0]; m_pg = s_pg[0]; m_ch = s_ch[0];
           m_pb = m_pg; m_cb = m_ch;
           for (int i = 0; i < 2; i++) begin
             s_pc[i] = s_pc[i+1]; s_pg[i] = s_pg[i+1]; s_ch[i] = s_ch[i+1];
           end
           s_pc[2] = 0; s_pg[2] = 0; s_ch[2] = 0;
           m_dep--;
         end
      default: begin
        if (o == 4) m_pb = tg & 15;
        if (o == 5) m_cb = tg & 3;
        if (inc != 0) m_pc = (m_pc + 1) & mask;
      end
    endcase
  endfunction

  function automatic string tag_of(int o, int st);
    case (o)
      1: return (st != 0) ? "R3" : "R4";
      2: return (st != 0) ? "R5" : "R6";
      3: return (m_dep > 0) ? "R7" : "R8";
      4, 5: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic check_out(string tag);
    checks++;
    if (int'(pc) != m_pc || int'(page) != m_pg || int'(chapter) != m_ch) begin
      failures++;
      $display("FAIL %s: pc/page/chapter actual %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, pc, page, chapter, m_pc, m_pg, m_ch);
    end
  endtask

  // drives at the falling edge, checks 1 ns after the rising edge
  task automatic apply(int o, int st, int tg, int inc, string force_tag);
    string t;
    @(negedge clk);
    op = 3'(o); status = st[0]; target = TGT_W'(tg); inc_en = inc[0];
    t = (force_tag != "") ? force_tag : tag_of(o, st);
    @(posedge clk);
    #1;
    model_step(o, st, tg, inc);
    check_out(t);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op = 3'd0; inc_en = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    check_out("R1");
    rst_n = 1'b1;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    model_reset();
    do_reset();

    // R8 return on empty stack straight after reset
    apply(3, 1, 0, 1, "R8");
    // R2 step with and without enable
    apply(0, 0, 0, 1, "R2");
    apply(0, 0, 0, 0, "R2");
    apply(7, 0, 0, 1, "R2");
    // R11 staged page/chapter reach outputs only through a branch
    apply(4, 0, 9, 0, "R11");
    apply(5, 0, 3, 0, "R11");
    apply(1, 1, 8'hD5, 0, "R11");
    // R4 untaken branch
    apply(1, 0, 12, 1, "R4");
    // R9 three nested calls with distinct pages and chapters, then unwind
    for (int k = 0; k < 3; k++) begin
      apply(4, 0, 3 + k, 1, "R11");
      apply(5, 0, k, 0, "R11");
      apply(2, 1, 10 + 7 * k, 0, "R9");
    end
    for (int k = 0; k < 3; k++) apply(3, 0, 0, 0, "R9");
    apply(3, 0, 0, 1, "R8");
    // R6 untaken call cancels staged target
    apply(4, 0, 14, 0, "R6");
    apply(2, 0, 40, 1, "R6");
    apply(1, 1, 41, 0, "R6");
    // R10 fourth call drops the oldest level
    for (int k = 0; k < 4; k++) begin
      apply(4, 0, 8 + k, 0, "R10");
      apply(5, 0, 3 - k, 0, "R10");
      apply(2, 1, 20 + k, 0, "R10");
    end
    for (int k = 0; k < 4; k++) apply(3, 1, 0, 0, "R10");
    // R1 reset from a busy state
    apply(2, 1, 33, 0, "R5");
    do_reset();
    apply(3, 0, 0, 0, "R1");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int o, st, tg, inc;
      o   = $urandom_range(0, 7);
      st  = $urandom_range(0, 1);
      tg  = $urandom_range(0, 255);
      inc = $urandom_range(0, 1);
      apply(o, st, tg, inc, "");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule